// File: doc/BRIEF.md
# Standby and Wake Mode Controller

This block decides the power mode of a chip that combines a supply regulator with a single-wire bus transceiver. Its inputs are digital flags from the analog front end: battery above its sense level, enable pin above its high threshold, enable pin below its low threshold, bus line level, supply above the minimum for bus operation, and over-temperature shutdown and recovery. Every flag comes in unsynchronised and passes through a two-flop synchroniser. The block drives four outputs: regulator-on, bus-driver enable, a strength select for the enable-pin pull-down, and a one-cycle request to the reset generator.

The regulator comes up on its own once the battery is present. A low enable switches it off only after the enable has first been seen high while running. In standby the chip wakes on a rising enable, or on a dominant (low) bus level that lasts a programmable number of clock ticks. Over-temperature overrides every other transition. Recovery from it restarts the chip with a fresh reset, whatever the enable and bus levels are.

Top module: `stby_wake_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, `regOn`, `busDrvEn`, `enPullStrong` and `resetReq` are all 0.
- R2: Once the synchronised battery flag is 1, the controller enters the running mode (`regOn`=1) and pulses `resetReq` high for exactly one cycle. The enable level plays no part in this.
- R3: While running, a low enable (`enLoAsync`=1) is ignored until the enable-high flag has been seen at 1 at least once since the controller last entered the running mode.
- R4: In standby, `regOn`=0, `busDrvEn`=0 and `enPullStrong`=1. In every other mode `enPullStrong`=0.
- R5: In standby, an enable-high flag of 1 returns the controller to running mode with one `resetReq` pulse.
- R6: The bus idles at level 1. In standby, a bus level of 0 held for `WAKE_TICKS` consecutive synchronised cycles (default 2250, which is 45 µs at 50 MHz) wakes the controller with one `resetReq` pulse. A low interval that ends earlier clears the count and causes no wake. Disabling is disarmed again after the wake.
- R7: An over-temperature shutdown flag forces `regOn`=0 and `busDrvEn`=0 from any mode. It takes priority over the enable, bus and battery inputs.
- R8: With the shutdown flag at 0, a recovery flag of 1 while thermally shut down restarts running mode with one `resetReq` pulse, whatever the enable and bus levels are. Disabling is disarmed after the restart.
- R9: `busDrvEn` is 1 only when `regOn` is 1 and the synchronised supply-ok flag is 1.
- R10: When the battery flag drops to 0, the controller goes unpowered (`regOn`=0) and disarms disabling. When the battery returns, turn-on is automatic again and is not undone by a low enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low asynchronous reset |
| battOkAsync | input | 1 | Battery above sense threshold |
| enHiAsync | input | 1 | Enable pin above high threshold |
| enLoAsync | input | 1 | Enable pin below low threshold |
| busLvlAsync | input | 1 | Bus line level, 1 = idle |
| supplyOkAsync | input | 1 | Supply above minimum bus-operation level |
| otShutAsync | input | 1 | Over-temperature shutdown |
| otRecAsync | input | 1 | Temperature back below recovery level |
| regOn | output | 1 | Regulator enable |
| busDrvEn | output | 1 | Bus driver enable (0 = high impedance) |
| enPullStrong | output | 1 | 1 selects the strong enable pull-down |
| resetReq | output | 1 | One-cycle restart request to the reset generator |

## Verification
The bench holds the enable low from power-up. A design that armed disabling without first seeing the enable high would drop straight into standby. The bus is driven low for a stretch just short of the qualifying window, released, and then driven low for a stretch just past it. A counter that was not cleared on release would accumulate the two stretches and wake early, and a wrong threshold would miss the second one. During thermal shutdown the bench raises the enable and toggles the bus, which an over-temperature input without priority would let restart the chip. After the thermal restart, after a bus wake and after a battery return, the bench holds the enable low. A controller that kept its armed status across those events would switch off at once. The bench also counts reset pulses, so a missing or doubled restart request shows up.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ON   = 2'd1,
    MODE_STBY = 2'd2,
    MODE_HOT  = 2'd3
  } mode_t;

  typedef struct packed {
    logic armClr;
    logic armSet;
    logic cntEn;
  } ctrlStrobes_t;

  localparam int FL_BATT   = 0;
  localparam int FL_ENHI   = 1;
  localparam int FL_ENLO   = 2;
  localparam int FL_BUS    = 3;
  localparam int FL_SUPPLY = 4;
  localparam int FL_OTSHUT = 5;
  localparam int FL_OTREC  = 6;
  localparam int FL_COUNT  = 7;
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int W = 7,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic stage1, stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= RST_VAL[i];
        stage2 <= RST_VAL[i];
      end else begin
        stage1 <= asyncIn[i];
        stage2 <= stage1;
      end
    end
    assign syncOut[i] = stage2;
  end
endmodule

// File: rtl/swc_datapath.sv
module swc_datapath
  import swc_pkg::*;
#(
  parameter int WAKE_TICKS = 2250
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         enHi,
  input  logic         busLvl,
  output logic         armed,
  output logic         wakeHit
);
  localparam int CW = $clog2(WAKE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE_TICKS - 1);

  logic [CW-1:0] lowCnt;
  logic busLow;

  assign busLow  = ~busLvl;
  assign wakeHit = strobes.cntEn && busLow && (lowCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (!strobes.cntEn || !busLow) begin
      lowCnt <= '0;
    end else if (!wakeHit) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (strobes.armClr) begin
      armed <= 1'b0;
    end else if (strobes.armSet && enHi) begin
      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/swc_ctrl.sv
module swc_ctrl
  import swc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         battOk,
  input  logic         enHi,
  input  logic         enLo,
  input  logic         supplyOk,
  input  logic         otShut,
  input  logic         otRec,
  input  logic         armed,
  input  logic         wakeHit,
  output ctrlStrobes_t strobes,
  output logic         regOn,
  output logic         busDrvEn,
  output logic         enPullStrong,
  output logic         resetReq
);
  mode_t mode, nextMode;
  logic  entering;

  always_comb begin
    nextMode = mode;
    if (otShut) begin
      nextMode = MODE_HOT;
    end else if (!battOk) begin
      nextMode = MODE_OFF;
    end else begin
      unique case (mode)
        MODE_OFF:  nextMode = MODE_ON;
        MODE_ON:   if (enLo && armed) nextMode = MODE_STBY;
        MODE_STBY: if (enHi || wakeHit) nextMode = MODE_ON;
        MODE_HOT:  if (otRec) nextMode = MODE_ON;
        default:   nextMode = MODE_OFF;
      endcase
    end
  end

  assign entering       = (nextMode == MODE_ON) && (mode != MODE_ON);
  assign strobes.armClr = entering || (nextMode == MODE_OFF);
  assign strobes.armSet = (mode == MODE_ON);
  assign strobes.cntEn  = (mode == MODE_STBY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= MODE_OFF;
      resetReq <= 1'b0;
    end else begin
      mode     <= nextMode;
      resetReq <= entering;
    end
  end

  assign regOn        = (mode == MODE_ON);
  assign busDrvEn     = regOn && supplyOk;
  assign enPullStrong = (mode == MODE_STBY);
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
  import swc_pkg::*;
#(
  parameter int WAKE_TICKS = 2250
) (
  input  logic clk,
  input  logic rstN,
  input  logic battOkAsync,
  input  logic enHiAsync,
  input  logic enLoAsync,
  input  logic busLvlAsync,
  input  logic supplyOkAsync,
  input  logic otShutAsync,
  input  logic otRecAsync,
  output logic regOn,
  output logic busDrvEn,
  output logic enPullStrong,
  output logic resetReq
);
  localparam logic [FL_COUNT-1:0] SYNC_RST = FL_COUNT'(1) << FL_BUS;

  logic [FL_COUNT-1:0] rawFlags, syncd;
  ctrlStrobes_t strobes;
  logic armed, wakeHit;

  assign rawFlags = {otRecAsync, otShutAsync, supplyOkAsync, busLvlAsync,
                     enLoAsync, enHiAsync, battOkAsync};

  swc_sync #(.W(FL_COUNT), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(rawFlags), .syncOut(syncd)
  );

  swc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .battOk(syncd[FL_BATT]), .enHi(syncd[FL_ENHI]), .enLo(syncd[FL_ENLO]),
    .supplyOk(syncd[FL_SUPPLY]), .otShut(syncd[FL_OTSHUT]), .otRec(syncd[FL_OTREC]),
    .armed(armed), .wakeHit(wakeHit), .strobes(strobes),
    .regOn(regOn), .busDrvEn(busDrvEn), .enPullStrong(enPullStrong), .resetReq(resetReq)
  );

  swc_datapath #(.WAKE_TICKS(WAKE_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .enHi(syncd[FL_ENHI]), .busLvl(syncd[FL_BUS]),
    .armed(armed), .wakeHit(wakeHit)
  );
endmodule

// File: rtl/swc_chk.sv
module swc_chk (
  input logic clk,
  input logic rstN,
  input logic regOn,
  input logic busDrvEn,
  input logic enPullStrong,
  input logic resetReq,
  input logic supplyS,
  input logic otShutS,
  input logic battS
);
  // R9
  drv_needs_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDrvEn |-> (regOn && supplyS));
  // R4
  strong_pull_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    enPullStrong |-> !regOn);
  // R2
  rise_has_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regOn) |-> resetReq);
  // R2
  reset_only_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> regOn);
  // R7
  hot_forces_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    otShutS |=> (!regOn && !busDrvEn));
  // R10
  batt_loss_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!battS && !otShutS) |=> !regOn);
  // R1
  always @(posedge clk) begin
    reset_quiet_chk: assert (rstN || (!regOn && !busDrvEn && !enPullStrong && !resetReq));
  end
endmodule

bind stby_wake_ctrl swc_chk u_chk (
  .clk(clk), .rstN(rstN), .regOn(regOn), .busDrvEn(busDrvEn),
  .enPullStrong(enPullStrong), .resetReq(resetReq),
  .supplyS(syncd[swc_pkg::FL_SUPPLY]), .otShutS(syncd[swc_pkg::FL_OTSHUT]),
  .battS(syncd[swc_pkg::FL_BATT])
);

// File: tb/sim_stby_wake_ctrl.sv
module sim_stby_wake_ctrl;
  localparam int WT = 2250;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic batt = 0, enHi = 0, enLo = 0, bus = 1, supply = 0, otShut = 0, otRec = 0;
  logic regOn, busDrvEn, enPullStrong, resetReq;
  int errors = 0, checks = 0, pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  stby_wake_ctrl #(.WAKE_TICKS(WT)) u0 (
    .clk(clk), .rstN(rstN), .battOkAsync(batt), .enHiAsync(enHi), .enLoAsync(enLo),
    .busLvlAsync(bus), .supplyOkAsync(supply), .otShutAsync(otShut), .otRecAsync(otRec),
    .regOn(regOn), .busDrvEn(busDrvEn), .enPullStrong(enPullStrong), .resetReq(resetReq)
  );

  always @(negedge clk) if (rstN && resetReq) pulses++;

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic check_int(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic t_reset();
    wait_n(3);
    check(regOn, 0, "R1 regOn in reset");
    check(busDrvEn | enPullStrong | resetReq, 0, "R1 outputs in reset");
    rstN = 1'b1;
    wait_n(2);
    check(regOn, 0, "R1 regOn after reset without battery");
  endtask

  task automatic t_power_up();
    enLo = 1;
    batt = 1;
    wait_n(6);
    check(regOn, 1, "R2 auto turn-on");
    check_int(pulses, 1, "R2 reset pulse count");
    check(enPullStrong, 0, "R4 weak pull while on");
    wait_n(10);
    check(regOn, 1, "R3 low enable ignored before arming");
    check(busDrvEn, 0, "R9 driver off without supply");
    supply = 1;
    wait_n(5);
    check(busDrvEn, 1, "R9 driver on with supply");
  endtask

  task automatic t_standby();
    enLo = 0; enHi = 1;
    wait_n(6);
    enHi = 0; enLo = 1;
    wait_n(6);
    check(regOn, 0, "R4 standby regOn");
    check(busDrvEn, 0, "R4 standby driver");
    check(enPullStrong, 1, "R4 strong pull in standby");
  endtask

  task automatic t_en_wake();
    enLo = 0; enHi = 1;
    wait_n(6);
    check(regOn, 1, "R5 enable wake");
    check_int(pulses, 2, "R5 reset pulse count");
    check(enPullStrong, 0, "R4 weak pull after wake");
    enHi = 0; enLo = 1;
    wait_n(6);
    check(regOn, 0, "R4 back to standby");
  endtask

  task automatic t_bus_wake();
    bus = 0;
    wait_n(WT - 250);
    bus = 1;
    wait_n(10);
    check(regOn, 0, "R6 short low pulse no wake");
    bus = 0;
    wait_n(WT - 250);
    check(regOn, 0, "R6 count cleared by idle");
    wait_n(300);
    check(regOn, 1, "R6 qualified bus wake");
    check_int(pulses, 3, "R6 reset pulse count");
    bus = 1;
    wait_n(10);
    check(regOn, 1, "R6 disarmed after bus wake");
  endtask

  task automatic t_thermal();
    otShut = 1;
    wait_n(6);
    check(regOn, 0, "R7 shutdown regOn");
    check(busDrvEn, 0, "R7 shutdown driver");
    enLo = 0; enHi = 1; bus = 0;
    wait_n(10);
    bus = 1;
    wait_n(6);
    check(regOn, 0, "R7 priority over enable and bus");
    check_int(pulses, 3, "R7 no restart while hot");
    enHi = 0; enLo = 1;
    otShut = 0; otRec = 1;
    wait_n(6);
    check(regOn, 1, "R8 thermal restart");
    check_int(pulses, 4, "R8 reset pulse count");
    otRec = 0;
    wait_n(10);
    check(regOn, 1, "R8 low enable ignored after restart");
  endtask

  task automatic t_batt_loss();
    enLo = 0; enHi = 1;
    wait_n(6);
    batt = 0;
    wait_n(6);
    check(regOn, 0, "R10 battery loss off");
    enHi = 0; enLo = 1;
    batt = 1;
    wait_n(6);
    check(regOn, 1, "R10 auto turn-on again");
    check_int(pulses, 5, "R10 reset pulse count");
    wait_n(10);
    check(regOn, 1, "R10 disarmed after battery loss");
  endtask

  initial begin
    t_reset();
    t_power_up();
    t_standby();
    t_en_wake();
    t_bus_wake();
    t_thermal();
    t_batt_loss();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule